// File: doc/BRIEF.md
# Sv32 Two-Level Page-Table Walker

This block turns a 32-bit virtual data address into a 34-bit physical address by walking a two-level Sv32 page table held in memory. A request carries the virtual address, the current value of the address-translation CSR and the privilege level. The block captures all three when it accepts the request. It then issues up to two word reads on a simple request/valid memory port and reports the physical address together with both page-table entries it consulted.

Machine mode and bare mode skip the walk. In both cases the virtual address passes through unchanged and no memory read is made. A first-level entry that is readable or executable ends the walk early as a 4 MiB superpage. A first-level entry that is not valid ends it with a fault. Any page-table entry output that the walk did not use reads as zero. The block has no translation cache and checks no permissions apart from detecting a leaf.

Top module: `sv32_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the edge after acceptance through the cycle in which `done` is high.
- R2: The first read goes to address `{satp[21:0], 12'b0} | (va[31:22] << 2)` (34 bits).
- R3: The second read goes to address `{pte1[31:10], 12'b0} | (va[21:12] << 2)`, where pte1 is the first-level entry that was read.
- R4: While `mem_rd_req` is high and `mem_rd_valid` is low, the request stays high and `mem_rd_addr` stays unchanged. The walk advances only on a cycle with `mem_rd_valid` high, and that cycle's `mem_rd_data` is taken as the entry.
- R5: When the privilege is 2'b11 or satp bit 31 is 0, the walk is bypassed. No memory read is made, `done` rises in the cycle after acceptance, `paddr` is the zero-extended virtual address, and both entry outputs are zero.
- R6: If pte1 has V (bit 0) set and R (bit 1) or X (bit 3) set, it is a superpage leaf. No second read is made, `paddr = {pte1[31:20], va[21:0]}`, `pte_l1` is pte1 and `pte_l0` is zero.
- R7: If pte1 has V (bit 0) clear, whatever its other bits, no second read is made. `fault` is high with `done`, `pte_l1` is the word read, `pte_l0` is zero and `paddr` is zero.
- R8: After a two-level walk, `paddr = {pte0[31:10], va[11:0]}` with the full 22-bit page number reaching bit 33. `fault` is low and both entries are reported.
- R9: `done` is high for exactly one cycle per accepted request. `paddr`, `pte_l1`, `pte_l0` and `fault` are valid in that cycle, and `fault` is never high without `done`.
- R10: Changes on `req_vaddr`, `req_satp`, `req_priv` or `req_valid` while a walk is in progress do not affect that walk's reads or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_satp | input | 32 | Translation CSR: bit 31 mode, bits 21:0 root page number |
| req_priv | input | 2 | Privilege level, 2'b11 is machine mode |
| mem_rd_req | output | 1 | Word read request, held until answered |
| mem_rd_addr | output | 34 | Physical byte address of the page-table entry |
| mem_rd_valid | input | 1 | Read data present this cycle |
| mem_rd_data | input | 32 | Page-table entry read |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | First-level entry invalid, valid with done |
| paddr | output | 34 | Translated physical address |
| pte_l1 | output | 32 | First-level entry used, zero if none |
| pte_l0 | output | 32 | Second-level entry used, zero if none |

## Verification
Two events can meet in the same cycle: the completion pulse of one walk, and a new request that is already waiting on the input. The bench provokes this by keeping `req_valid` high with the values of a second translation while the first walk is still running, so the second request is already pending when `done` fires. The scoreboard then judges three things. The first result must reflect only the captured request. `req_ready` must be low in the `done` cycle. The second request must be taken only on the following idle edge, with its own reads and its own result. Memory latencies of zero, one, two and three cycles shift where the completion cycle falls relative to the waiting request.

// File: rtl/sv32w_pkg.sv
// Shared widths, bit positions and state types for the Sv32 page-table walker.
// Assumes the fixed Sv32 geometry: 32-bit VA, 34-bit PA, 4-byte entries.
package sv32w_pkg;
    localparam int SV_VA_W      = 32;
    localparam int SV_PA_W      = 34;
    localparam int SV_PTE_W     = 32;
    localparam int SV_VPN_W     = 10;
    localparam int SV_OFF_W     = 12;
    localparam int SV_PRIV_W    = 2;
    localparam int SV_IDX_SHIFT = 2;
    localparam int SV_PPN_W     = SV_PA_W - SV_OFF_W;
    localparam int SV_PPN1_W    = SV_PPN_W - SV_VPN_W;
    localparam int SV_FLAG_W    = SV_PTE_W - SV_PPN_W;

    localparam int SV_BIT_V       = 0;
    localparam int SV_BIT_R       = 1;
    localparam int SV_BIT_X       = 3;
    localparam int SV_SATP_MODE_B = 31;

    localparam logic [SV_PRIV_W-1:0] SV_PRIV_M = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_L1,
        ST_RD_L0,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_BYPASS,
        KIND_SUPER,
        KIND_FAULT,
        KIND_PAGE
    } walk_kind_e;
endpackage

// File: rtl/sv32w_pte_class.sv
// Classifies one page-table entry word as valid and/or leaf.
// Assumes the entry is only used while a read response is present.
module sv32w_pte_class
    import sv32w_pkg::*;
#(
    parameter int PTE_W = SV_PTE_W,
    parameter int BIT_V = SV_BIT_V,
    parameter int BIT_R = SV_BIT_R,
    parameter int BIT_X = SV_BIT_X
) (
    input  logic [PTE_W-1:0] pte,
    output logic             is_valid,
    output logic             is_leaf
);
    // decode the flag bits that steer the walk
    always_comb begin
        is_valid = pte[BIT_V];
        is_leaf  = pte[BIT_R] | pte[BIT_X];
    end
endmodule

// File: rtl/sv32w_addr_gen.sv
// Forms the physical address of the page-table entry for the current level.
// Assumes table bases are page aligned and entries are 2**IDX_SHIFT bytes.
module sv32w_addr_gen
    import sv32w_pkg::*;
#(
    parameter int VA_W      = SV_VA_W,
    parameter int PA_W      = SV_PA_W,
    parameter int PTE_W     = SV_PTE_W,
    parameter int VPN_W     = SV_VPN_W,
    parameter int OFF_W     = SV_OFF_W,
    parameter int IDX_SHIFT = SV_IDX_SHIFT
) (
    input  logic [PA_W-OFF_W-1:0] root_ppn,
    input  logic [VA_W-1:0]       vaddr,
    input  logic [PTE_W-1:0]      pte_hi,
    input  logic                  use_l0,
    output logic [PA_W-1:0]       pte_addr
);
    localparam int PPN_W = PA_W - OFF_W;
    localparam int IDX_W = VPN_W + IDX_SHIFT;

    logic [PPN_W-1:0] base;
    logic [VPN_W-1:0] vpn;

    // pick table base and index for the level being read, then merge
    always_comb begin
        if (use_l0) begin
            base = pte_hi[PTE_W-1 -: PPN_W];
            vpn  = vaddr[OFF_W +: VPN_W];
        end else begin
            base = root_ppn;
            vpn  = vaddr[VA_W-1 -: VPN_W];
        end
        pte_addr = {base, {OFF_W{1'b0}}}
                 | {{(PA_W-IDX_W){1'b0}}, vpn, {IDX_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/sv32w_result.sv
// Builds the reported physical address from the captured walk outcome.
// Assumes kind, vaddr and entries are stable while done is high.
module sv32w_result
    import sv32w_pkg::*;
#(
    parameter int VA_W  = SV_VA_W,
    parameter int PA_W  = SV_PA_W,
    parameter int PTE_W = SV_PTE_W,
    parameter int VPN_W = SV_VPN_W,
    parameter int OFF_W = SV_OFF_W
) (
    input  walk_kind_e       kind,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PTE_W-1:0] pte_hi,
    input  logic [PTE_W-1:0] pte_lo,
    output logic [PA_W-1:0]  paddr
);
    localparam int PPN_W  = PA_W - OFF_W;
    localparam int PPN1_W = PPN_W - VPN_W;
    localparam int SPO_W  = OFF_W + VPN_W;

    // select the address form that matches how the walk ended
    always_comb begin
        unique case (kind)
            KIND_BYPASS: paddr = {{(PA_W-VA_W){1'b0}}, vaddr};
            KIND_SUPER:  paddr = {pte_hi[PTE_W-1 -: PPN1_W], vaddr[SPO_W-1:0]};
            KIND_PAGE:   paddr = {pte_lo[PTE_W-1 -: PPN_W], vaddr[OFF_W-1:0]};
            default:     paddr = '0;
        endcase
    end
endmodule

// File: rtl/sv32w_ctrl.sv
// Walk sequencer: accepts a request in idle, captures it, steps through the
// two table reads and classifies the outcome. Assumes the memory answers
// each held request eventually and that mem_rd_data is valid with its flag.
module sv32w_ctrl
    import sv32w_pkg::*;
#(
    parameter int VA_W   = SV_VA_W,
    parameter int PTE_W  = SV_PTE_W,
    parameter int PPN_W  = SV_PPN_W,
    parameter int PRIV_W = SV_PRIV_W,
    parameter int MODE_B = SV_SATP_MODE_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PTE_W-1:0]  req_satp,
    input  logic [PRIV_W-1:0] req_priv,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    input  logic              rsp_valid_bit,
    input  logic              rsp_leaf,
    output logic              req_ready,
    output logic              mem_rd_req,
    output logic              use_l0,
    output logic [VA_W-1:0]   cap_vaddr,
    output logic [PPN_W-1:0]  cap_root,
    output logic [PTE_W-1:0]  pte_hi_q,
    output logic [PTE_W-1:0]  pte_lo_q,
    output walk_kind_e        kind_q,
    output logic              done,
    output logic              fault
);
    walk_state_e state_q, state_d;
    logic        accept;
    logic        bypass;

    assign accept = req_valid && (state_q == ST_IDLE);
    assign bypass = (req_priv == SV_PRIV_M) || !req_satp[MODE_B];

    // next-state selection for the walk
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = bypass ? ST_DONE : ST_RD_L1;
            ST_RD_L1: if (mem_rd_valid)
                          state_d = (!rsp_valid_bit || rsp_leaf) ? ST_DONE : ST_RD_L0;
            ST_RD_L0: if (mem_rd_valid) state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // capture the request fields once, at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vaddr <= '0;
            cap_root  <= '0;
        end else if (accept) begin
            cap_vaddr <= req_vaddr;
            cap_root  <= req_satp[PPN_W-1:0];
        end
    end

    // hold the entries read; clearing at acceptance gives the zero rule
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_hi_q <= '0;
            pte_lo_q <= '0;
        end else if (accept) begin
            pte_hi_q <= '0;
            pte_lo_q <= '0;
        end else if (mem_rd_valid && state_q == ST_RD_L1) begin
            pte_hi_q <= mem_rd_data;
        end else if (mem_rd_valid && state_q == ST_RD_L0) begin
            pte_lo_q <= mem_rd_data;
        end
    end

    // record how the walk ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_BYPASS;
        end else if (accept) begin
            kind_q <= bypass ? KIND_BYPASS : KIND_PAGE;
        end else if (mem_rd_valid && state_q == ST_RD_L1) begin
            if (!rsp_valid_bit) kind_q <= KIND_FAULT;
            else if (rsp_leaf)  kind_q <= KIND_SUPER;
        end
    end

    // decode outputs from state
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_rd_req = (state_q == ST_RD_L1) || (state_q == ST_RD_L0);
        use_l0     = (state_q == ST_RD_L0);
        done       = (state_q == ST_DONE);
        fault      = done && (kind_q == KIND_FAULT);
    end

    p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_req && !done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_bypass_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && ((req_priv == SV_PRIV_M) || !req_satp[MODE_B]))
        |=> (done && !mem_rd_req));

    p_leaf_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !use_l0 && mem_rd_valid && (!rsp_valid_bit || rsp_leaf))
        |=> done);
endmodule

// File: rtl/sv32_walker.sv
// Top of the Sv32 page-table walker: joins sequencer, entry classifier,
// entry address former and result former. Assumes a memory that answers
// each held read with one mem_rd_valid cycle.
module sv32_walker
    import sv32w_pkg::*;
#(
    parameter int VA_W   = SV_VA_W,
    parameter int PA_W   = SV_PA_W,
    parameter int PTE_W  = SV_PTE_W,
    parameter int PRIV_W = SV_PRIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PTE_W-1:0]  req_satp,
    input  logic [PRIV_W-1:0] req_priv,
    output logic              mem_rd_req,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              done,
    output logic              fault,
    output logic [PA_W-1:0]   paddr,
    output logic [PTE_W-1:0]  pte_l1,
    output logic [PTE_W-1:0]  pte_l0
);
    localparam int PPN_W = PA_W - SV_OFF_W;

    logic             rsp_v, rsp_leaf, use_l0;
    logic [VA_W-1:0]  cap_vaddr;
    logic [PPN_W-1:0] cap_root;
    logic [PTE_W-1:0] pte_hi_q, pte_lo_q;
    walk_kind_e       kind_q;

    sv32w_pte_class #(.PTE_W(PTE_W)) u_class (
        .pte      (mem_rd_data),
        .is_valid (rsp_v),
        .is_leaf  (rsp_leaf)
    );

    sv32w_ctrl #(
        .VA_W(VA_W), .PTE_W(PTE_W), .PPN_W(PPN_W), .PRIV_W(PRIV_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_satp      (req_satp),
        .req_priv      (req_priv),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_data   (mem_rd_data),
        .rsp_valid_bit (rsp_v),
        .rsp_leaf      (rsp_leaf),
        .req_ready     (req_ready),
        .mem_rd_req    (mem_rd_req),
        .use_l0        (use_l0),
        .cap_vaddr     (cap_vaddr),
        .cap_root      (cap_root),
        .pte_hi_q      (pte_hi_q),
        .pte_lo_q      (pte_lo_q),
        .kind_q        (kind_q),
        .done          (done),
        .fault         (fault)
    );

    sv32w_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)
    ) u_addr (
        .root_ppn (cap_root),
        .vaddr    (cap_vaddr),
        .pte_hi   (pte_hi_q),
        .use_l0   (use_l0),
        .pte_addr (mem_rd_addr)
    );

    sv32w_result #(
        .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W)
    ) u_res (
        .kind   (kind_q),
        .vaddr  (cap_vaddr),
        .pte_hi (pte_hi_q),
        .pte_lo (pte_lo_q),
        .paddr  (paddr)
    );

    // report captured entries straight out
    always_comb begin
        pte_l1 = pte_hi_q;
        pte_l0 = pte_lo_q;
    end

    p_hold_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (paddr == '0 && pte_l0 == '0));

    p_fault_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);

    p_l0_after_l1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && use_l0) |-> (pte_l1[SV_BIT_V] && !pte_l1[SV_BIT_R] && !pte_l1[SV_BIT_X]));
endmodule

// File: tb/sv32_walker_tb_top.sv
// Scoreboard bench: the driver pushes the expected reads and results, a
// memory model answers reads, and a monitor compares each result at done.
module sv32_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_satp = '0;
    logic [1:0]  req_priv = '0;
    logic        mem_rd_req;
    logic [33:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done, fault;
    logic [33:0] paddr;
    logic [31:0] pte_l1, pte_l0;

    always #4 clk = ~clk;

    sv32_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_satp(req_satp), .req_priv(req_priv),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .done(done), .fault(fault), .paddr(paddr),
        .pte_l1(pte_l1), .pte_l0(pte_l0)
    );

    typedef struct {
        logic [33:0] pa;
        logic [31:0] p1;
        logic [31:0] p0;
        logic        flt;
        int          nrd;
        logic [33:0] a1;
        logic [33:0] a0;
        string       tag;
    } exp_t;

    logic [31:0] pt_mem [logic [33:0]];
    exp_t        exp_q[$];
    logic [33:0] addr_q[$];
    string       atag_q[$];
    int          n_checks = 0;
    int          n_errs = 0;
    int          lat = 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(input logic [33:0] a);
        return pt_mem.exists(a) ? pt_mem[a] : 32'h0;
    endfunction

    function automatic logic [33:0] l1_addr(input logic [31:0] st, input logic [31:0] va);
        return (34'(st & 32'h003f_ffff) << 12) | 34'(((va >> 22) & 32'h3ff) << 2);
    endfunction

    function automatic logic [33:0] l0_addr(input logic [31:0] p1, input logic [31:0] va);
        return (34'(p1 >> 10) << 12) | 34'(((va >> 12) & 32'h3ff) << 2);
    endfunction

    // reference outcome computed from the requirement formulas
    function automatic exp_t ref_walk(input logic [31:0] va, input logic [31:0] st,
                                      input logic [1:0] pv);
        exp_t e;
        e.pa = '0; e.p1 = '0; e.p0 = '0; e.flt = 1'b0; e.nrd = 0;
        e.a1 = '0; e.a0 = '0; e.tag = "";
        if (pv == 2'd3 || st[31] == 1'b0) begin
            e.pa = {2'b00, va};
        end else begin
            e.nrd = 1;
            e.a1 = l1_addr(st, va);
            e.p1 = rd(e.a1);
            if (!e.p1[0]) begin
                e.flt = 1'b1;
            end else if (e.p1[1] || e.p1[3]) begin
                e.pa = (34'(e.p1 >> 20) << 22) | 34'(va & 32'h003f_ffff);
            end else begin
                e.nrd = 2;
                e.a0 = l0_addr(e.p1, va);
                e.p0 = rd(e.a0);
                e.pa = (34'(e.p0 >> 10) << 12) | 34'(va & 32'hfff);
            end
        end
        return e;
    endfunction

    // driver: present a request, push expectations on the accepting cycle
    task automatic issue(input logic [31:0] va, input logic [31:0] st,
                         input logic [1:0] pv, input string tag, input bit keep);
        exp_t e;
        e = ref_walk(va, st, pv);
        e.tag = tag;
        req_vaddr = va; req_satp = st; req_priv = pv; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        if (e.nrd >= 1) begin addr_q.push_back(e.a1); atag_q.push_back("R2"); end
        if (e.nrd == 2) begin addr_q.push_back(e.a0); atag_q.push_back("R3"); end
        @(negedge clk);
        if (!keep) req_valid = 1'b0;
    endtask

    // memory model: check addresses, hold-until-answered, respond after lat
    bit          m_busy = 1'b0;
    int          m_cnt = 0;
    logic [33:0] m_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_valid) begin
                mem_rd_valid = 1'b0;
                m_busy = 1'b0;
            end else begin
                if (mem_rd_req && !m_busy) begin
                    if (addr_q.size() == 0) begin
                        chk(1'b0, "R5/R6/R7", "unexpected table read", 64'(mem_rd_addr), 64'h0);
                    end else begin
                        string t;
                        logic [33:0] ea;
                        ea = addr_q.pop_front();
                        t = atag_q.pop_front();
                        chk(mem_rd_addr == ea, t, "read address", 64'(mem_rd_addr), 64'(ea));
                    end
                    chk(req_ready == 1'b0, "R1", "ready during walk", 64'(req_ready), 64'h0);
                    m_busy = 1'b1; m_cnt = lat; m_addr = mem_rd_addr;
                end else if (m_busy) begin
                    chk(mem_rd_req && mem_rd_addr == m_addr, "R4", "read held",
                        {29'h0, mem_rd_req, mem_rd_addr}, {29'h0, 1'b1, m_addr});
                end
                if (m_busy) begin
                    if (m_cnt == 0) begin
                        mem_rd_valid = 1'b1;
                        mem_rd_data = rd(m_addr);
                    end else begin
                        m_cnt--;
                    end
                end
            end
        end
    end

    // monitor: pop and compare at each done, check pulse shape
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault && !done) chk(1'b0, "R9", "fault without done", 64'(fault), 64'h0);
            if (prev_done && done) chk(1'b0, "R9", "done longer than one cycle", 64'h1, 64'h0);
            if (done) begin
                chk(req_ready == 1'b0, "R1", "ready in done cycle", 64'(req_ready), 64'h0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "done without request", 64'h1, 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(paddr == e.pa, e.tag, "paddr", 64'(paddr), 64'(e.pa));
                    chk(pte_l1 == e.p1, e.tag, "pte_l1", 64'(pte_l1), 64'(e.p1));
                    chk(pte_l0 == e.p0, e.tag, "pte_l0", 64'(pte_l0), 64'(e.p0));
                    chk(fault == e.flt, e.tag, "fault", 64'(fault), 64'(e.flt));
                end
            end
            prev_done = done;
        end
    end

    bit finished = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

    localparam logic [31:0] SATP_ON = 32'h8000_0123;
    localparam logic [31:0] VA_A = 32'h4050_1ABC;
    localparam logic [31:0] VA_B = 32'h8123_4567;
    localparam logic [31:0] VA_C = 32'hC000_0010;
    localparam logic [31:0] VA_F = 32'h0CA0_0F00;
    localparam logic [31:0] VA_G = 32'h1230_0000;
    localparam logic [31:0] VA_H = 32'h7FFF_F123;

    initial begin
        logic [31:0] p;
        p = {22'h000456, 10'h001};
        pt_mem[l1_addr(SATP_ON, VA_A)] = p;
        pt_mem[l0_addr(p, VA_A)] = {22'h03ABCD, 10'h0CF};
        pt_mem[l1_addr(SATP_ON, VA_B)] = {12'hABC, 10'h000, 10'h003};
        pt_mem[l1_addr(SATP_ON, VA_F)] = {22'h000111, 10'h009};
        pt_mem[l1_addr(SATP_ON, VA_G)] = {22'h000777, 10'h002};
        p = {22'h000200, 10'h001};
        pt_mem[l1_addr(SATP_ON, VA_H)] = p;
        pt_mem[l0_addr(p, VA_H)] = {22'h3FFFFF, 10'h0CF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", 64'(req_ready), 64'h1);
        chk(done == 1'b0 && fault == 1'b0, "R9", "reset done/fault", {62'h0, done, fault}, 64'h0);
        chk(mem_rd_req == 1'b0, "R4", "reset read request", 64'(mem_rd_req), 64'h0);

        lat = 1; issue(VA_A, SATP_ON, 2'd1, "R8", 1'b0);
        lat = 0; issue(VA_B, SATP_ON, 2'd0, "R6", 1'b0);
        lat = 3; issue(VA_C, SATP_ON, 2'd1, "R7", 1'b0);
        issue(VA_A, SATP_ON, 2'd3, "R5", 1'b0);
        issue(32'hDEAD_BEEF, 32'h0000_0123, 2'd1, "R5", 1'b0);
        lat = 2; issue(VA_F, SATP_ON, 2'd1, "R6", 1'b0);
        issue(VA_G, SATP_ON, 2'd0, "R7", 1'b0);
        lat = 1; issue(VA_H, SATP_ON, 2'd0, "R8", 1'b0);
        // pending request held during walks: R10
        lat = 2; issue(VA_A, SATP_ON, 2'd1, "R10", 1'b1);
        issue(VA_B, SATP_ON, 2'd1, "R10", 1'b1);
        lat = 0; issue(VA_H, SATP_ON, 2'd1, "R10", 1'b1);
        issue(VA_C, 32'h0000_0000, 2'd0, "R5", 1'b0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(addr_q.size() == 0, "R3", "reads outstanding", 64'(addr_q.size()), 64'h0);
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule